// File: doc/BRIEF.md
# Write-Masked PHY Configuration Register Bridge

This block connects a plain 32-bit memory-mapped bus to the configuration side of a serial-link PHY. It decodes three words. The configuration word holds a write strobe, a PHY register address and a PHY data nibble. The lane word holds one idle control for each lane. The status word is read-only and reports the two PLL flags together with the nibble stored at the current PHY address.

The two writable words use a write-mask scheme. In each bus write, the upper half-word says which bits of the lower half-word may change. Software can therefore change a single field without reading the word first.

A rising edge on the strobe bit commits the current address and data into a small internal array of PHY configuration registers. The commit also produces a one-cycle pulse that carries the committed address and data. The PLL itself is outside the block and arrives as two input flags.

Top module: `phy_cfg_bridge`

## Requirements
- R1: On a write to a writable word, lower bit x takes the written value only when bit x+16 of the same write is 1; otherwise it keeps its previous value.
- R2: The configuration word sits at offset 0xe220. Bit 0 is the strobe, bits 6:1 the PHY address and bits 10:7 the PHY data. `phy_addr` and `phy_data` follow these fields from the clock edge that takes the write.
- R3: A 0-to-1 change of the strobe bit stores `phy_data` into the internal array at `phy_addr`. On the following edge `commit_pulse` goes high for one cycle, with `commit_addr` and `commit_data` holding the committed values. This also applies when a single write sets the strobe and changes the fields.
- R4: Keeping the strobe at 1, rewriting it with 1, or clearing it to 0 produces no commit pulse and no array write.
- R5: The lane word sits at offset 0xe214. Bits 3, 4, 5 and 6 are the idle controls for lanes 0 to 3 and drive `lane_idle[0..3]`; a 1 idles the lane.
- R6: The status word sits at offset 0xe2a4 and reads as `pll_locked` in bit 9, `pll_out_flag` in bit 10, and the array entry at the current `phy_addr` in bits 4:1. All other bits read 0.
- R7: Writes to the status word have no effect on any register or on the array.
- R8: Bits 31:16 of every read are 0. Lower bits outside the defined fields of a word are not stored and read as 0.
- R9: Writes to undecoded offsets are ignored, and reads of undecoded offsets return 0.
- R10: After reset the configuration word and every array entry are 0, all four lane idle bits are 1 (lane word reads 0x78), and `commit_pulse` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access valid |
| bus_we | input | 1 | Write when high, with bus_sel |
| bus_addr | input | 16 | Byte offset of the access |
| bus_wdata | input | 32 | Write data: upper half is the mask, lower half the value |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| pll_locked | input | 1 | PLL lock flag from the PHY |
| pll_out_flag | input | 1 | PLL output flag from the PHY |
| phy_addr | output | 6 | Current PHY configuration address |
| phy_data | output | 4 | Current PHY configuration data |
| lane_idle | output | 4 | Per-lane idle control, 1 = idled |
| commit_pulse | output | 1 | One-cycle pulse after a strobe rise |
| commit_addr | output | 6 | Address committed by the last pulse |
| commit_data | output | 4 | Data committed by the last pulse |

## Verification
Most wrong internal states in this block show up at the ports within a cycle or two. A corrupted mask bit or field register changes `phy_addr`, `phy_data`, `lane_idle` or the word readback on the edge after the write. A wrong strobe history shows up one edge after the write, either as a missing or repeated `commit_pulse` or as a pulse carrying the wrong payload. A wrong array write stays hidden until the status word is read with `phy_addr` pointing at that entry. The bench therefore moves the address back over entries it has already committed and reads the nibble back through the status word.

// File: rtl/phy_cfg_pkg.sv
`timescale 1ns/1ps
package phy_cfg_pkg;
   typedef enum logic [1:0] {
      WSEL_NONE = 2'd0,
      WSEL_CFG  = 2'd1,
      WSEL_LANE = 2'd2,
      WSEL_STAT = 2'd3
   } word_sel_e;

   localparam int unsigned HALF_W = 16;
   localparam int unsigned BUS_W  = 2 * HALF_W;
endpackage

// File: rtl/pcb_masked_word.sv
`timescale 1ns/1ps
module pcb_masked_word #(
   parameter int unsigned W = 16,
   parameter logic [W-1:0] RST_VAL = '0,
   parameter logic [W-1:0] IMPL = '1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           we,
   input  logic [2*W-1:0] wdata,
   output logic [W-1:0]   q
);
   logic [W-1:0] en_bits;
   logic [W-1:0] q_next;

   generate
      if (W < 1 || W > 32) begin : g_bad_w
         $error("pcb_masked_word: W out of range");
      end
   endgenerate

   always_comb begin
      en_bits = wdata[2*W-1:W] & IMPL;
      q_next  = (q & ~en_bits) | (wdata[W-1:0] & en_bits);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= RST_VAL & IMPL;
      else if (we) q <= q_next;
   end

   // R1
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> $stable(q));

   genvar gi;
   generate
      for (gi = 0; gi < W; gi++) begin : g_bit
         // R1
         masked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (we && !wdata[W+gi]) |=> (q[gi] == $past(q[gi])));
         if (!IMPL[gi]) begin : g_unimpl
            // R8
            unimpl_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
               q[gi] == 1'b0);
         end
      end
   endgenerate
endmodule

// File: rtl/pcb_commit.sv
`timescale 1ns/1ps
module pcb_commit #(
   parameter int unsigned ADDR_W = 6,
   parameter int unsigned DATA_W = 4,
   parameter bit CLEAR_ON_RESET = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              strobe,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic              commit_pulse,
   output logic [ADDR_W-1:0] commit_addr,
   output logic [DATA_W-1:0] commit_data
);
   localparam int unsigned DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] mem [DEPTH];
   logic              strobe_q;
   logic              rise;

   generate
      if (ADDR_W > 10) begin : g_bad_depth
         $error("pcb_commit: array too deep");
      end
   endgenerate

   assign rise    = strobe & ~strobe_q;
   assign rd_data = mem[rd_addr];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         strobe_q     <= 1'b0;
         commit_pulse <= 1'b0;
         commit_addr  <= '0;
         commit_data  <= '0;
      end else begin
         strobe_q     <= strobe;
         commit_pulse <= rise;
         if (rise) begin
            commit_addr <= addr;
            commit_data <= data;
         end
      end
   end

   generate
      if (CLEAR_ON_RESET) begin : g_clr
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            end else if (rise) begin
               mem[addr] <= data;
            end
         end
      end else begin : g_noclr
         always_ff @(posedge clk) begin
            if (rise) mem[addr] <= data;
         end
      end
   endgenerate

   // R4
   one_shot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      commit_pulse |=> !commit_pulse);

   // R3
   payload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      commit_pulse |-> (commit_addr == $past(addr) && commit_data == $past(data)));

   // R3
   stored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      commit_pulse |-> (mem[commit_addr] == commit_data || rise));

   // R4
   no_spur_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe && $past(strobe)) |=> !commit_pulse);
endmodule

// File: rtl/phy_cfg_bridge.sv
`timescale 1ns/1ps
module phy_cfg_bridge
   import phy_cfg_pkg::*;
#(
   parameter int unsigned ADDR_W    = 6,
   parameter int unsigned DATA_W    = 4,
   parameter int unsigned LANES     = 4,
   parameter int unsigned LANE_LSB  = 3,
   parameter int unsigned OFF_W     = 16,
   parameter logic [OFF_W-1:0] CFG_OFF  = 16'he220,
   parameter logic [OFF_W-1:0] LANE_OFF = 16'he214,
   parameter logic [OFF_W-1:0] STAT_OFF = 16'he2a4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_we,
   input  logic [OFF_W-1:0]  bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic              pll_locked,
   input  logic              pll_out_flag,
   output logic [ADDR_W-1:0] phy_addr,
   output logic [DATA_W-1:0] phy_data,
   output logic [LANES-1:0]  lane_idle,
   output logic              commit_pulse,
   output logic [ADDR_W-1:0] commit_addr,
   output logic [DATA_W-1:0] commit_data
);
   localparam int unsigned ADDR_LSB = 1;
   localparam int unsigned DATA_LSB = ADDR_LSB + ADDR_W;
   localparam int unsigned CFG_TOP  = DATA_LSB + DATA_W;
   localparam int unsigned LOCK_BIT = 9;
   localparam int unsigned OUT_BIT  = 10;
   localparam logic [HALF_W-1:0] CFG_IMPL  = HALF_W'((1 << CFG_TOP) - 1);
   localparam logic [HALF_W-1:0] LANE_IMPL = HALF_W'(((1 << LANES) - 1) << LANE_LSB);

   generate
      if (CFG_TOP > HALF_W) begin : g_bad_cfg
         $error("phy_cfg_bridge: config fields exceed half word");
      end
      if (LANE_LSB + LANES > HALF_W) begin : g_bad_lane
         $error("phy_cfg_bridge: lane field exceeds half word");
      end
      if (DATA_W + 1 > LOCK_BIT) begin : g_bad_stat
         $error("phy_cfg_bridge: readback overlaps PLL flags");
      end
   endgenerate

   word_sel_e         wsel;
   logic [HALF_W-1:0] cfg_q;
   logic [HALF_W-1:0] lane_q;
   logic [HALF_W-1:0] stat_lo;
   logic [DATA_W-1:0] rb_data;
   logic              wr;

   always_comb begin
      unique case (bus_addr)
         CFG_OFF:  wsel = WSEL_CFG;
         LANE_OFF: wsel = WSEL_LANE;
         STAT_OFF: wsel = WSEL_STAT;
         default:  wsel = WSEL_NONE;
      endcase
   end

   assign wr = bus_sel & bus_we;

   pcb_masked_word #(
      .W       (HALF_W),
      .RST_VAL ('0),
      .IMPL    (CFG_IMPL)
   ) u_cfg_word (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (wr && wsel == WSEL_CFG),
      .wdata (bus_wdata),
      .q     (cfg_q)
   );

   pcb_masked_word #(
      .W       (HALF_W),
      .RST_VAL (LANE_IMPL),
      .IMPL    (LANE_IMPL)
   ) u_lane_word (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (wr && wsel == WSEL_LANE),
      .wdata (bus_wdata),
      .q     (lane_q)
   );

   assign phy_addr  = cfg_q[DATA_LSB-1:ADDR_LSB];
   assign phy_data  = cfg_q[CFG_TOP-1:DATA_LSB];
   assign lane_idle = lane_q[LANE_LSB+LANES-1:LANE_LSB];

   pcb_commit #(
      .ADDR_W         (ADDR_W),
      .DATA_W         (DATA_W),
      .CLEAR_ON_RESET (1'b1)
   ) u_commit (
      .clk          (clk),
      .rst_n        (rst_n),
      .strobe       (cfg_q[0]),
      .addr         (phy_addr),
      .data         (phy_data),
      .rd_addr      (phy_addr),
      .rd_data      (rb_data),
      .commit_pulse (commit_pulse),
      .commit_addr  (commit_addr),
      .commit_data  (commit_data)
   );

   always_comb begin
      stat_lo                  = '0;
      stat_lo[DATA_W:1]        = rb_data;
      stat_lo[LOCK_BIT]        = pll_locked;
      stat_lo[OUT_BIT]         = pll_out_flag;
   end

   always_comb begin
      bus_rdata = '0;
      case (wsel)
         WSEL_CFG:  bus_rdata[HALF_W-1:0] = cfg_q;
         WSEL_LANE: bus_rdata[HALF_W-1:0] = lane_q;
         WSEL_STAT: bus_rdata[HALF_W-1:0] = stat_lo;
         default:   bus_rdata = '0;
      endcase
   end

   // R8
   upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rdata[31:16] == 16'h0);

   // R9
   undecoded_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr != CFG_OFF && bus_addr != LANE_OFF && bus_addr != STAT_OFF)
         |-> bus_rdata == 32'h0);

   // R7
   stat_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && bus_addr == STAT_OFF) |=> ($stable(cfg_q) && $stable(lane_q)));
endmodule

// File: tb/test_phy_cfg_bridge.sv
`timescale 1ns/1ps
module test_phy_cfg_bridge;
   localparam logic [15:0] CFG  = 16'he220;
   localparam logic [15:0] LANE = 16'he214;
   localparam logic [15:0] STAT = 16'he2a4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0;
   logic        bus_we = 1'b0;
   logic [15:0] bus_addr = 16'h0;
   logic [31:0] bus_wdata = 32'h0;
   logic [31:0] bus_rdata;
   logic        pll_locked = 1'b0;
   logic        pll_out_flag = 1'b0;
   logic [5:0]  phy_addr;
   logic [3:0]  phy_data;
   logic [3:0]  lane_idle;
   logic        commit_pulse;
   logic [5:0]  commit_addr;
   logic [3:0]  commit_data;

   int checks = 0;
   int failures = 0;
   logic [9:0] exp_q [$];

   always #2.5 clk = ~clk;

   phy_cfg_bridge i_phy_cfg_bridge (
      .clk          (clk),
      .rst_n        (rst_n),
      .bus_sel      (bus_sel),
      .bus_we       (bus_we),
      .bus_addr     (bus_addr),
      .bus_wdata    (bus_wdata),
      .bus_rdata    (bus_rdata),
      .pll_locked   (pll_locked),
      .pll_out_flag (pll_out_flag),
      .phy_addr     (phy_addr),
      .phy_data     (phy_data),
      .lane_idle    (lane_idle),
      .commit_pulse (commit_pulse),
      .commit_addr  (commit_addr),
      .commit_data  (commit_data)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [15:0] a, input logic [31:0] d);
      bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_we = 1'b0; bus_wdata = 32'h0;
   endtask

   task automatic rd(input logic [15:0] a, input logic [31:0] exp, input string req);
      bus_addr = a;
      #1;
      check(req, bus_rdata, exp);
      @(negedge clk);
   endtask

   task automatic wr_commit(input logic [15:0] a, input logic [31:0] d,
                            input logic [5:0] ea, input logic [3:0] ed);
      exp_q.push_back({ea, ed});
      wr(a, d);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   // Monitor: compares every commit pulse with the scoreboard queue (R3, R4)
   always @(negedge clk) begin
      if (rst_n && commit_pulse) begin
         if (exp_q.size() == 0) begin
            check("R4 unexpected commit pulse", 32'd1, 32'd0);
         end else begin
            logic [9:0] e;
            e = exp_q.pop_front();
            check("R3 commit payload", {22'h0, commit_addr, commit_data}, {22'h0, e});
         end
      end
   end

   initial begin
      #500000;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      idle(3);
      // R10 reset state
      check("R10 commit_pulse low in reset", {31'h0, commit_pulse}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      rd(CFG, 32'h0, "R10 cfg word reset");
      rd(LANE, 32'h78, "R10 lane word reset");
      rd(STAT, 32'h0, "R10 status array entry 0 reset");
      check("R10 lane_idle reset", {28'h0, lane_idle}, 32'hf);
      check("R10 phy_addr reset", {26'h0, phy_addr}, 32'h0);

      // R2 field placement, strobe untouched
      wr(CFG, {16'h07fe, 16'h0420});
      check("R2 phy_addr", {26'h0, phy_addr}, 32'h10);
      check("R2 phy_data", {28'h0, phy_data}, 32'h8);
      rd(CFG, 32'h420, "R2 cfg readback");
      idle(2);

      // R3 strobe rise commits addr 0x10 data 8
      wr_commit(CFG, {16'h0001, 16'h0001}, 6'h10, 4'h8);
      idle(3);
      // R4 strobe rewritten with 1, then cleared: no pulses
      wr(CFG, {16'h0001, 16'h0001});
      idle(3);
      wr(CFG, {16'h0001, 16'h0000});
      idle(3);
      check("R4 no pending commits", exp_q.size(), 32'h0);

      // R3 single write sets strobe and fields
      wr_commit(CFG, {16'h07ff, 16'h07ff}, 6'h3f, 4'hf);
      idle(3);
      rd(CFG, 32'h7ff, "R3 cfg after combined write");

      // R1 mask clear: nothing changes
      wr(CFG, {16'h0000, 16'h0000});
      rd(CFG, 32'h7ff, "R1 zero mask keeps word");
      // R1 single bit mask: data lsb cleared only
      wr(CFG, {16'h0080, 16'h0000});
      rd(CFG, 32'h77f, "R1 single masked bit");
      check("R1 phy_data after masked write", {28'h0, phy_data}, 32'he);

      // R6 status readback
      pll_locked = 1'b1;
      rd(STAT, 32'h21e, "R6 status lock and entry 0x3f");
      wr(CFG, {16'h007e, 16'h0020});
      rd(CFG, 32'h721, "R1 addr field rewrite");
      rd(STAT, 32'h210, "R6 status entry 0x10");
      pll_out_flag = 1'b1;
      rd(STAT, 32'h610, "R6 status out flag");

      // R7 status write ignored
      wr(STAT, 32'hffff_ffff);
      rd(STAT, 32'h610, "R7 status after write");
      rd(CFG, 32'h721, "R7 cfg after status write");
      rd(LANE, 32'h78, "R7 lane after status write");

      // R5 lane controls
      wr(LANE, {16'h0010, 16'h0000});
      check("R5 lane 1 awake", {28'h0, lane_idle}, 32'hd);
      rd(LANE, 32'h68, "R5 lane readback");
      wr(LANE, {16'h0000, 16'hffff});
      check("R1 lane unmasked write", {28'h0, lane_idle}, 32'hd);
      wr(LANE, {16'h0048, 16'h0000});
      check("R5 lanes 0 and 3 awake", {28'h0, lane_idle}, 32'h4);
      wr(LANE, 32'hffff_ffff);
      rd(LANE, 32'h78, "R8 lane undefined bits read zero");

      // R9 undecoded offset
      wr(16'he218, 32'hffff_ffff);
      rd(16'he218, 32'h0, "R9 undecoded read");
      rd(CFG, 32'h721, "R9 cfg untouched");
      check("R9 lane untouched", {28'h0, lane_idle}, 32'hf);

      // R8 all ones to cfg, strobe already high: no pulse
      wr(CFG, 32'hffff_ffff);
      rd(CFG, 32'h7ff, "R8 cfg undefined bits read zero");
      idle(3);
      rd(STAT, 32'h61e, "R6 status after final write");
      check("R3 scoreboard drained", exp_q.size(), 32'h0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule